// File: doc/BRIEF.md
# Endpoint Transmit Packet Buffer with DMA Fill

This block is the transmit-side store for a single bulk IN endpoint of a USB device controller. It holds one packet of at most 64 bytes. A DMA engine fills it one byte at a time through a request/acknowledge handshake, and a host-side read port drains each packet once it is committed for sending. The block raises its DMA request whenever DMA mode is on and the buffer is open for filling. The request stays up even after the application has no more data, until software turns DMA mode off.

A packet is committed in one of two ways. When a DMA write brings the buffer to 64 bytes, the block commits the packet by itself. A shorter final packet is committed when software pulses a commit strobe, normally from its transfer-end interrupt handler. A software commit made while a packet is already committed, which includes a full 64-byte packet, is ignored and raises a one-cycle error pulse. Each time the last byte of a committed packet is drained, an empty/transfer-end flag sets. Software clears that flag by writing 0 to it, but only after it has turned DMA mode off.

The control is a three-state machine. FILL accepts DMA bytes. HELD holds a committed packet that has not been touched yet. DRAIN is entered once part of the packet has been read. The transitions are:
- FILL to HELD, on an automatic commit (the 64th byte) or on an accepted software commit.
- HELD to DRAIN, on the first host read of a packet longer than one byte.
- HELD to FILL, on the read of a one-byte packet.
- DRAIN to FILL, on the read of the final byte.

Top module: `ep_tx_fifo_dma`

## Requirements
- R1: After reset, `dreq`, `pkt_valid`, `tx_flag` and `commit_err` are all 0, and the buffer is empty and in the filling state.
- R2: `dreq` is 1 exactly when `dma_en` is 1 and no committed packet is pending. It stays 1 while DMA mode is on, even when no more data is offered, and it goes to 0 in the same cycle that `dma_en` goes to 0.
- R3: A byte on `dma_wdata` is stored only in a cycle where `dack` and `dreq` are both 1. `dack` while `dreq` is 0 leaves the buffer contents and count unchanged.
- R4: The clock edge that stores the 64th byte commits the packet by itself. From the next cycle, `pkt_valid`=1, `pkt_len`=64 and `pkt_auto`=1, and `dreq`=0.
- R5: A `sw_commit` pulse in the filling state with 1 to 63 bytes stored commits a short packet: `pkt_valid`=1, `pkt_len` equals the byte count, and `pkt_auto`=0. With 0 bytes stored the pulse has no effect. Without the pulse, a short packet is never committed.
- R6: A `sw_commit` pulse while a packet is pending, including a full 64-byte packet, is ignored (`pkt_len` and `pkt_auto` are unchanged), and `commit_err` is 1 for exactly the following cycle.
- R7: While `pkt_valid` is 1, `host_rdata` shows the packet bytes in the order they were written, and each `host_rd` pulse advances to the next byte. `host_last` is 1 on the final byte. Reading the final byte empties the buffer and returns it to filling (`pkt_valid`=0 in the next cycle).
- R8: `tx_flag` sets on the clock edge that reads the final byte of a committed packet.
- R9: A `flag_wr` with `flag_wdata`=0 while `dma_en`=0 clears `tx_flag`. A write with `flag_wdata`=1, or a write of 0 while `dma_en`=1, leaves it set.
- R10: A 150-byte DMA transfer gives two automatic 64-byte packets and one 22-byte packet committed by software. A transfer whose length is a multiple of 64 needs no software commit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| dma_en | input | 1 | DMA mode enable, a level set by software |
| dreq | output | 1 | DMA request: the buffer is open for a byte |
| dack | input | 1 | DMA acknowledge: `dma_wdata` is valid this cycle |
| dma_wdata | input | 8 | DMA write data byte |
| sw_commit | input | 1 | Software packet-commit strobe |
| flag_wr | input | 1 | Software write strobe to the empty/transfer-end flag |
| flag_wdata | input | 1 | Value written to the flag (only 0 clears it) |
| tx_flag | output | 1 | Empty/transfer-end interrupt flag |
| commit_err | output | 1 | One-cycle pulse: a software commit was ignored |
| pkt_valid | output | 1 | A committed packet is waiting to be read |
| pkt_len | output | 7 | Length of the committed packet (0 when none) |
| pkt_auto | output | 1 | 1 if the pending packet was committed automatically |
| host_rd | input | 1 | Host-side read strobe: consume the current byte |
| host_rdata | output | 8 | Current byte of the committed packet |
| host_last | output | 1 | The current byte is the packet's final byte |

## Verification
The hardest case to reach from the ports is a software commit that lands while a full 64-byte packet is still pending. It needs exactly 64 accepted handshakes with no host read in between, then a strobe in the window before draining begins. The bench reaches it with a directed fill that stops the host reader until the automatic commit has happened, pulses the strobe and `dack` inside that window, and then drains the packet to show that the length, the source and all 64 bytes survived. The flag-clear sequence is also awkward: the flag sets after every drained packet while DMA mode is still on. So each transfer ends by trying the clear writes that must fail before it disables DMA and writes the one that succeeds.

// File: rtl/ep_tx_pkg.sv
package ep_tx_pkg;

    typedef enum logic [1:0] {
        ST_FILL  = 2'd0,
        ST_HELD  = 2'd1,
        ST_DRAIN = 2'd2
    } tx_state_e;

endpackage

// File: rtl/ep_tx_buf.sv
module ep_tx_buf #(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 64,
    localparam int PTR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [PTR_W-1:0]  wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [PTR_W-1:0]  rd_addr,
    output logic [DATA_W-1:0] rd_data
);

    logic [DATA_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[wr_addr] <= wr_data;
        end
    end

    assign rd_data = mem[rd_addr];

endmodule

// File: rtl/ep_tx_flag.sv
module ep_tx_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic wr_i,
    input  logic wdata_i,
    input  logic dma_en,
    output logic flag_o
);

    logic clr;

    // only a zero write with DMA mode off clears the flag
    assign clr = wr_i && !wdata_i && !dma_en;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flag_o <= 1'b0;
        end else if (set_i) begin
            flag_o <= 1'b1;
        end else if (clr) begin
            flag_o <= 1'b0;
        end
    end

endmodule

// File: rtl/ep_tx_ctrl.sv
module ep_tx_ctrl
    import ep_tx_pkg::*;
#(
    parameter int DEPTH  = 64,
    localparam int CNT_W = $clog2(DEPTH + 1),
    localparam int PTR_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             dma_en,
    input  logic             dack,
    input  logic             sw_commit,
    input  logic             host_rd,
    output logic             dreq,
    output logic             wr_en,
    output logic [PTR_W-1:0] wr_addr,
    output logic [PTR_W-1:0] rd_addr,
    output logic             pkt_valid,
    output logic [CNT_W-1:0] pkt_len,
    output logic             pkt_auto,
    output logic             host_last,
    output logic             drain_done,
    output logic             commit_err,
    output logic [CNT_W-1:0] fill_cnt
);

    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);
    localparam logic [CNT_W-1:0] ONE_CNT  = CNT_W'(1);

    tx_state_e        state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic [PTR_W-1:0] rd_q, rd_d;
    logic             auto_q, auto_d;
    logic             err_q;

    logic             in_fill;
    logic [CNT_W-1:0] cnt_inc;
    logic             hit_full;
    logic             sw_ok;
    logic             sw_bad;
    logic             rd_fire;
    logic             at_last;

    // ---------------- state register ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_FILL;
            cnt_q   <= '0;
            rd_q    <= '0;
            auto_q  <= 1'b0;
            err_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            rd_q    <= rd_d;
            auto_q  <= auto_d;
            err_q   <= sw_bad;
        end
    end

    // ---------------- decode of events ----------------
    always_comb begin
        in_fill  = (state_q == ST_FILL);
        cnt_inc  = cnt_q + ONE_CNT;
        hit_full = in_fill && dma_en && dack && (cnt_inc == FULL_CNT);
        sw_ok    = sw_commit && in_fill && !hit_full
                   && ((cnt_q != '0) || (dma_en && dack));
        sw_bad   = sw_commit && (!in_fill || hit_full);
        rd_fire  = host_rd && !in_fill;
        at_last  = (CNT_W'(rd_q) == (cnt_q - ONE_CNT));
    end

    // ---------------- next state ----------------
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        rd_d    = rd_q;
        auto_d  = auto_q;
        unique case (state_q)
            ST_FILL: begin
                if (dma_en && dack) begin
                    cnt_d = cnt_inc;
                end
                if (hit_full) begin
                    state_d = ST_HELD;
                    auto_d  = 1'b1;
                end else if (sw_ok) begin
                    state_d = ST_HELD;
                    auto_d  = 1'b0;
                end
                rd_d = '0;
            end
            ST_HELD: begin
                if (rd_fire) begin
                    if (at_last) begin
                        state_d = ST_FILL;
                        cnt_d   = '0;
                        rd_d    = '0;
                    end else begin
                        state_d = ST_DRAIN;
                        rd_d    = rd_q + PTR_W'(1);
                    end
                end
            end
            ST_DRAIN: begin
                if (rd_fire) begin
                    if (at_last) begin
                        state_d = ST_FILL;
                        cnt_d   = '0;
                        rd_d    = '0;
                    end else begin
                        rd_d = rd_q + PTR_W'(1);
                    end
                end
            end
            default: begin
                state_d = ST_FILL;
                cnt_d   = '0;
                rd_d    = '0;
            end
        endcase
    end

    // ---------------- outputs ----------------
    always_comb begin
        dreq       = in_fill && dma_en;
        wr_en      = in_fill && dma_en && dack;
        wr_addr    = cnt_q[PTR_W-1:0];
        rd_addr    = rd_q;
        pkt_valid  = !in_fill;
        pkt_len    = in_fill ? '0 : cnt_q;
        pkt_auto   = !in_fill && auto_q;
        host_last  = !in_fill && at_last;
        drain_done = rd_fire && at_last;
        commit_err = err_q;
        fill_cnt   = cnt_q;
    end

endmodule

// File: rtl/ep_tx_fifo_dma.sv
module ep_tx_fifo_dma #(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 64,
    localparam int CNT_W = $clog2(DEPTH + 1),
    localparam int PTR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              dma_en,
    output logic              dreq,
    input  logic              dack,
    input  logic [DATA_W-1:0] dma_wdata,
    input  logic              sw_commit,
    input  logic              flag_wr,
    input  logic              flag_wdata,
    output logic              tx_flag,
    output logic              commit_err,
    output logic              pkt_valid,
    output logic [CNT_W-1:0]  pkt_len,
    output logic              pkt_auto,
    input  logic              host_rd,
    output logic [DATA_W-1:0] host_rdata,
    output logic              host_last
);

    logic             wr_en;
    logic [PTR_W-1:0] wr_addr;
    logic [PTR_W-1:0] rd_addr;
    logic             drain_done;
    logic [CNT_W-1:0] fill_cnt;

    ep_tx_ctrl #(.DEPTH(DEPTH)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .dma_en     (dma_en),
        .dack       (dack),
        .sw_commit  (sw_commit),
        .host_rd    (host_rd),
        .dreq       (dreq),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .rd_addr    (rd_addr),
        .pkt_valid  (pkt_valid),
        .pkt_len    (pkt_len),
        .pkt_auto   (pkt_auto),
        .host_last  (host_last),
        .drain_done (drain_done),
        .commit_err (commit_err),
        .fill_cnt   (fill_cnt)
    );

    ep_tx_buf #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_buf (
        .clk     (clk),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (dma_wdata),
        .rd_addr (rd_addr),
        .rd_data (host_rdata)
    );

    ep_tx_flag u_flag (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_i   (drain_done),
        .wr_i    (flag_wr),
        .wdata_i (flag_wdata),
        .dma_en  (dma_en),
        .flag_o  (tx_flag)
    );

endmodule

// File: rtl/ep_tx_chk.sv
module ep_tx_chk #(
    parameter int DEPTH  = 64,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             dma_en,
    input logic             dack,
    input logic             sw_commit,
    input logic             host_rd,
    input logic             flag_wr,
    input logic             flag_wdata,
    input logic             dreq,
    input logic             pkt_valid,
    input logic [CNT_W-1:0] pkt_len,
    input logic             pkt_auto,
    input logic             commit_err,
    input logic             tx_flag,
    input logic [CNT_W-1:0] fill_cnt,
    input logic             drain_done
);

    // R2
    req_blocked_when_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_valid |-> !dreq);

    // R2
    req_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !dma_en |-> !dreq);

    // R2
    req_held_while_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_en && !pkt_valid) |-> dreq);

    // R4
    auto_commit_on_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dreq && dack && fill_cnt == CNT_W'(DEPTH - 1))
        |=> (pkt_valid && pkt_auto && pkt_len == CNT_W'(DEPTH)));

    // R5
    sw_commit_short_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_commit && !pkt_valid && fill_cnt != '0 && !(dreq && dack))
        |=> (pkt_valid && !pkt_auto && pkt_len == $past(fill_cnt)));

    // R6
    sw_commit_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_commit && pkt_valid) |=> commit_err);

    // R6
    sw_commit_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_commit && pkt_valid && !host_rd) |=> (pkt_valid && $stable(pkt_len) && $stable(pkt_auto)));

    // R7
    pending_len_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pkt_valid && !host_rd) |=> (pkt_valid && $stable(pkt_len)));

    // R7
    pending_len_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_valid |-> (pkt_len != '0 && pkt_len <= CNT_W'(DEPTH)));

    // R8
    flag_set_on_drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
        drain_done |=> tx_flag);

    // R9
    flag_kept_while_dma_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_flag && dma_en) |=> tx_flag);

    // R9
    flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_wr && !flag_wdata && !dma_en && !drain_done) |=> !tx_flag);

    // R9
    flag_write_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_flag && flag_wr && flag_wdata) |=> tx_flag);

endmodule

bind ep_tx_fifo_dma ep_tx_chk #(.DEPTH(DEPTH)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .dma_en     (dma_en),
    .dack       (dack),
    .sw_commit  (sw_commit),
    .host_rd    (host_rd),
    .flag_wr    (flag_wr),
    .flag_wdata (flag_wdata),
    .dreq       (dreq),
    .pkt_valid  (pkt_valid),
    .pkt_len    (pkt_len),
    .pkt_auto   (pkt_auto),
    .commit_err (commit_err),
    .tx_flag    (tx_flag),
    .fill_cnt   (fill_cnt),
    .drain_done (drain_done)
);

// File: tb/tb_ep_tx_fifo_dma.sv
module tb_ep_tx_fifo_dma;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       dma_en = 1'b0;
    logic       dreq;
    logic       dack = 1'b0;
    logic [7:0] dma_wdata = '0;
    logic       sw_commit = 1'b0;
    logic       flag_wr = 1'b0;
    logic       flag_wdata = 1'b0;
    logic       tx_flag;
    logic       commit_err;
    logic       pkt_valid;
    logic [6:0] pkt_len;
    logic       pkt_auto;
    logic       host_rd = 1'b0;
    logic [7:0] host_rdata;
    logic       host_last;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    ep_tx_fifo_dma dut (
        .clk(clk), .rst_n(rst_n), .dma_en(dma_en), .dreq(dreq), .dack(dack),
        .dma_wdata(dma_wdata), .sw_commit(sw_commit), .flag_wr(flag_wr),
        .flag_wdata(flag_wdata), .tx_flag(tx_flag), .commit_err(commit_err),
        .pkt_valid(pkt_valid), .pkt_len(pkt_len), .pkt_auto(pkt_auto),
        .host_rd(host_rd), .host_rdata(host_rdata), .host_last(host_last)
    );

    // transfer length, expected automatic commits, expected short tail
    localparam int NVEC = 3;
    localparam int VEC [NVEC][3] = '{
        '{150, 2, 22},
        '{128, 2, 0},
        '{1,   0, 1}
    };

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic drain(int n, bit exp_auto, int base, string req);
        chk(req, "pkt_valid before drain", int'(pkt_valid), 1);
        chk(req, "pkt_len", int'(pkt_len), n);
        chk(req, "pkt_auto", int'(pkt_auto), int'(exp_auto));
        chk("R2", "dreq low while pending", int'(dreq), 0);
        for (int i = 0; i < n; i++) begin
            chk("R7", "host_rdata", int'(host_rdata), (base + i) & 255);
            chk("R7", "host_last", int'(host_last), (i == n - 1) ? 1 : 0);
            host_rd = 1'b1;
            tick();
            host_rd = 1'b0;
        end
        chk("R7", "pkt_valid after drain", int'(pkt_valid), 0);
        chk("R8", "tx_flag after drain", int'(tx_flag), 1);
    endtask

    task automatic flag_write(bit v);
        flag_wr = 1'b1;
        flag_wdata = v;
        tick();
        flag_wr = 1'b0;
        flag_wdata = 1'b0;
    endtask

    task automatic put_byte(int v);
        dack = 1'b1;
        dma_wdata = 8'(v);
        tick();
        dack = 1'b0;
    endtask

    task automatic pulse_commit();
        sw_commit = 1'b1;
        tick();
        sw_commit = 1'b0;
    endtask

    task automatic run_xfer(int len, int exp_auto, int exp_short, int base);
        int sent = 0;
        int used = 0;
        int autos = 0;
        int guard = 0;
        dma_en = 1'b1;
        #1;
        chk("R2", "dreq on enable", int'(dreq), 1);
        while (sent < len && guard < 5000) begin
            guard++;
            if (dreq) begin
                put_byte(base + sent);
                sent++;
            end else if (pkt_valid) begin
                drain(64, 1'b1, base + used, "R4");
                used += 64;
                autos++;
            end else begin
                tick();
            end
        end
        if (pkt_valid) begin
            drain(64, 1'b1, base + used, "R4");
            used += 64;
            autos++;
        end
        chk("R10", "automatic commits", autos, exp_auto);
        chk("R2", "dreq held with no more data", int'(dreq), 1);
        if (exp_short > 0) begin
            tick();
            chk("R5", "no commit without strobe", int'(pkt_valid), 0);
            pulse_commit();
            drain(exp_short, 1'b0, base + used, "R10");
        end
        chk("R8", "flag pending at end", int'(tx_flag), 1);
        flag_write(1'b0);
        chk("R9", "zero write with dma on ignored", int'(tx_flag), 1);
        dma_en = 1'b0;
        #1;
        chk("R2", "dreq drops with dma off", int'(dreq), 0);
        flag_write(1'b1);
        chk("R9", "one write ignored", int'(tx_flag), 1);
        flag_write(1'b0);
        chk("R9", "zero write clears", int'(tx_flag), 0);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL R10 watchdog: actual=timeout expected=completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin : main
        repeat (3) @(posedge clk);
        #1;
        // R1 reset state
        chk("R1", "dreq", int'(dreq), 0);
        chk("R1", "pkt_valid", int'(pkt_valid), 0);
        chk("R1", "tx_flag", int'(tx_flag), 0);
        chk("R1", "commit_err", int'(commit_err), 0);
        rst_n = 1'b1;
        tick();
        chk("R1", "dreq after release", int'(dreq), 0);

        // vector table walk: R10 transfer shapes
        for (int v = 0; v < NVEC; v++) begin
            run_xfer(VEC[v][0], VEC[v][1], VEC[v][2], 16 * v + 3);
        end

        // R5 commit with empty buffer has no effect
        pulse_commit();
        chk("R5", "empty commit ignored", int'(pkt_valid), 0);
        chk("R6", "empty commit no error", int'(commit_err), 0);

        // R3 acknowledge without request ignored
        dack = 1'b1;
        dma_wdata = 8'hAA;
        repeat (3) tick();
        dack = 1'b0;
        dma_en = 1'b1;
        #1;
        put_byte(8'h40);
        put_byte(8'h41);
        pulse_commit();
        drain(2, 1'b0, 8'h40, "R3");

        // R6 commit while full packet pending, plus dack while pending (R3)
        for (int i = 0; i < 64; i++) begin
            put_byte(100 + i);
        end
        chk("R4", "dreq low after 64th", int'(dreq), 0);
        sw_commit = 1'b1;
        dack = 1'b1;
        dma_wdata = 8'hEE;
        tick();
        sw_commit = 1'b0;
        dack = 1'b0;
        chk("R6", "commit_err pulse", int'(commit_err), 1);
        chk("R6", "len unchanged", int'(pkt_len), 64);
        chk("R6", "source unchanged", int'(pkt_auto), 1);
        tick();
        chk("R6", "commit_err one cycle", int'(commit_err), 0);
        drain(64, 1'b1, 100, "R3");

        dma_en = 1'b0;
        flag_write(1'b0);
        chk("R9", "final clear", int'(tx_flag), 0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule